// File: doc/BRIEF.md
# Reverse-Accumulation FIR Filter with Spaced Pipeline Cuts

This block is an N-tap finite impulse response filter for signed fixed-point samples. Samples and coefficients are L bits wide in two's complement. Every product is kept at its full 2L-bit precision, and the sum grows by ceil(log2 N) guard bits. The partial sum does not run from the newest tap toward the oldest, as the textbook direct form does. It starts at the oldest tap and flows toward the newest.

A register is placed on the accumulation path after every group of K multiply-add sections, so the adder chain is broken into N/K short segments. A plain pipeline would need one wide register per tap. Here each sample-path tap is instead read one delay position further down the shared sample line, one position for each cut crossed. The result is the exact direct-form convolution, delayed by a fixed number of accepted samples.

The pipeline advances only when a sample is accepted (`in_valid` high). An output strobe follows each accepted sample by one clock. A warm-up counter keeps that strobe low until the cut registers hold real data, so the first strobed result is the response to the first sample after reset. Coefficients come from a flat register vector that the surrounding logic holds steady while samples flow.

Top module: `fir_rev_retimed`

## Requirements
- R1: While `rst` is high at a clock edge, all sample-history and cut registers are cleared to zero. After that edge, `out_valid` is 0 and `out_data` is 0.
- R2: Let x[k] be the k-th sample accepted since reset and c[i] the coefficient of tap i. Write y[k] = sum over i of c[i]·x[k−i], with x taken as 0 before reset. After accepted sample s, with s ≥ LAT = N/K − 1, `out_data` equals y[s−LAT] in the following cycle.
- R3: `out_valid` is high for exactly the one cycle after each accepted sample, and only once LAT samples have already been accepted since reset. The first strobed value is therefore y[0].
- R4: A cycle with `in_valid` low changes no state. In the following cycle `out_valid` is 0 and `out_data` keeps its value, so gaps in the input stream do not alter any later result.
- R5: Arithmetic is two's complement at full precision. `out_data` is 2L+ceil(log2 N) bits wide and never wraps. With every sample and coefficient at −2^(L−1), the output settles at N·2^(2L−2).
- R6: Coefficient i sits at `coef_flat[i*L +: L]` and weights the sample accepted i positions earlier. An impulse input therefore reproduces c[0], c[1], …, c[N−1] on successive strobes.
- R7: The cut spacing K (a divisor of N: 2, 4, 8 or 16) sets the latency to N/K − 1 accepted samples and changes nothing else. With K = N the output is strobed after every accepted sample with no warm-up.
- R8: A reset in the middle of a stream discards all earlier samples. The results after it depend only on samples accepted after the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accepts `in_data` on this edge and advances the pipeline |
| in_data | input | L | Signed input sample |
| coef_flat | input | N·L | Coefficients, tap i at bits i·L upward |
| out_valid | output | 1 | High for one cycle when `out_data` holds a new result |
| out_data | output | 2L+ceil(log2 N) | Signed filter result |

## Verification
The assertions watch, on every cycle, the rules that need no arithmetic model. An idle cycle must leave the output frozen with no strobe. A strobe is only allowed right after an accepted sample. The output must stay within the bound set by the worst-case operands. Reset must clear the output. Only the bench scenarios can show the numeric behaviour, because they compare against a reference convolution. These scenarios cover the latency and warm-up for two cut spacings, the tap-to-coefficient order revealed by an impulse, the extreme-operand sum, and the loss of history after a mid-stream reset.

// File: rtl/fir_rev_retimed.sv
module fir_rev_retimed #(
  parameter int N = 8,
  parameter int L = 8,
  parameter int K = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  input  logic signed [L-1:0]               in_data,
  input  logic [N*L-1:0]                    coef_flat,
  output logic                              out_valid,
  output logic signed [2*L+$clog2(N)-1:0]   out_data
);
  localparam int G   = N / K;
  localparam int LAT = G - 1;
  localparam int W   = 2*L + $clog2(N);
  localparam int CW  = $clog2(G) + 1;
  localparam logic signed [W-1:0] BOUND = W'(longint'(N) << (2*L-2));

  logic signed [L-1:0] dl [1:N-1];
  logic signed [W-1:0] acc [G];
  logic signed [W-1:0] chain [N];
  logic [CW-1:0] fill;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int m = 1; m < N; m++) dl[m] <= '0;
      fill      <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid && (fill == CW'(LAT));
      if (in_valid) begin
        dl[1] <= in_data;
        for (int m = 2; m < N; m++) dl[m] <= dl[m-1];
        if (fill != CW'(LAT)) fill <= fill + 1'b1;
      end
    end
  end

  // step j handles tap N-1-j; taps past each cut read one slot further back
  for (genvar j = 0; j < N; j++) begin : g_step
    localparam int TI = N - 1 - j;
    localparam int GI = j / K;
    localparam int XI = TI + GI;
    logic signed [L-1:0]   xs;
    logic signed [L-1:0]   cs;
    logic signed [2*L-1:0] pr;
    logic signed [W-1:0]   sin;
    assign cs = coef_flat[TI*L +: L];
    if (XI == 0) begin : g_live
      assign xs = in_data;
    end else begin : g_hist
      assign xs = dl[XI];
    end
    assign pr = cs * xs;
    if (j % K == 0) begin : g_head
      if (GI == 0) begin : g_first
        assign sin = '0;
      end else begin : g_cut
        assign sin = acc[GI-1];
      end
    end else begin : g_link
      assign sin = chain[j-1];
    end
    assign chain[j] = sin + W'(pr);
  end

  for (genvar g = 0; g < G; g++) begin : g_cutreg
    always_ff @(posedge clk) begin
      if (rst) acc[g] <= '0;
      else if (in_valid) acc[g] <= chain[g*K + K - 1];
    end
  end

  assign out_data = acc[G-1];

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_data == '0));

  assert_strobe_cause_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_data) && !out_valid));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (out_data <= BOUND) && (out_data >= -BOUND));
endmodule

// File: tb/fir_rev_retimed_tb.sv
`timescale 1ns/1ps
module fir_rev_retimed_tb;
  localparam int N = 8;
  localparam int L = 8;
  localparam int W = 2*L + $clog2(N);
  localparam int LATA = 3;
  localparam int NS = 1024;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic vin = 1'b0;
  logic signed [L-1:0] din = '0;
  logic [N*L-1:0] coef = '0;
  logic va, vb;
  logic signed [W-1:0] da, db;

  fir_rev_retimed #(.N(N), .L(L), .K(2)) u_dut (
    .clk(clk), .rst(rst), .in_valid(vin), .in_data(din), .coef_flat(coef),
    .out_valid(va), .out_data(da));
  fir_rev_retimed #(.N(N), .L(L), .K(8)) u_dut_k8 (
    .clk(clk), .rst(rst), .in_valid(vin), .in_data(din), .coef_flat(coef),
    .out_valid(vb), .out_data(db));

  int checks = 0, fails = 0, s = 0;
  bit done = 0;
  longint xs [NS];
  logic signed [W-1:0] prev_a, prev_b;

  function automatic longint cval(int i);
    logic signed [L-1:0] c;
    c = coef[i*L +: L];
    return longint'(c);
  endfunction

  function automatic longint yref(int idx);
    longint acc = 0;
    for (int i = 0; i < N; i++)
      if (idx - i >= 0) acc += cval(i) * xs[idx-i];
    return acc;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit v, logic signed [L-1:0] x);
    @(negedge clk);
    vin = v; din = x;
    @(posedge clk); #1;
    if (v) begin
      xs[s] = longint'(x);
      check(va == (s >= LATA), "R3 strobe", va, (s >= LATA));
      if (s >= LATA) check(longint'(da) == yref(s - LATA), "R2 value", da, yref(s - LATA));
      check(vb == 1'b1, "R7 strobe k8", vb, 1);
      check(longint'(db) == yref(s), "R7 value k8", db, yref(s));
      s++;
    end else begin
      check(!va && da == prev_a, "R4 idle", da, prev_a);
      check(!vb && db == prev_b, "R4 idle k8", db, prev_b);
    end
    prev_a = da; prev_b = db;
  endtask

  task automatic do_reset(logic [N*L-1:0] c);
    @(negedge clk);
    rst = 1'b1; vin = 1'b0; coef = c;
    repeat (2) @(posedge clk);
    #1;
    check(!va && da == '0 && !vb && db == '0, "R1 reset", da, 0);
    @(negedge clk);
    rst = 1'b0;
    s = 0; prev_a = '0; prev_b = '0;
  endtask

  function automatic logic [N*L-1:0] rand_coef();
    logic [N*L-1:0] c;
    for (int i = 0; i < N; i++) c[i*L +: L] = L'($urandom);
    return c;
  endfunction

  initial begin
    logic [N*L-1:0] c;
    void'($urandom(32'd4242));
    // R2/R3/R4: random stream with random gaps
    do_reset(rand_coef());
    for (int k = 0; k < 300; k++) step(($urandom % 4) != 0, L'($urandom));
    for (int k = 0; k < 10; k++) step(1'b0, '0);
    for (int k = 0; k < 20; k++) step(1'b1, L'($urandom));

    // R6: impulse reveals coefficient order
    for (int i = 0; i < N; i++) c[i*L +: L] = (i % 2 == 1) ? L'(-(i + 3)) : L'(i + 5);
    do_reset(c);
    step(1'b1, 8'sd1);
    for (int k = 1; k < N + 6; k++) begin
      step(1'b1, '0);
      if (k >= LATA && k - LATA < N)
        check(longint'(da) == cval(k - LATA), "R6 impulse", da, cval(k - LATA));
    end

    // R5: most negative operands everywhere
    for (int i = 0; i < N; i++) c[i*L +: L] = 8'h80;
    do_reset(c);
    for (int k = 0; k < 16; k++) step(1'b1, 8'sh80);
    check(longint'(da) == longint'(N) * 16384, "R5 extreme", da, longint'(N) * 16384);
    for (int k = 0; k < 16; k++) step(1'b1, (k % 2) ? 8'sh7f : 8'sh80);

    // R8: reset in mid-stream drops history
    do_reset(rand_coef());
    for (int k = 0; k < 40; k++) step(1'b1, L'($urandom));
    do_reset(coef);
    for (int k = 0; k < 4; k++) step(1'b1, L'($urandom));
    check(longint'(da) == cval(0) * xs[0], "R8 fresh history", da, cval(0) * xs[0]);
    for (int k = 0; k < 100; k++) step(($urandom % 3) != 0, L'($urandom));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule